// File: doc/BRIEF.md
# Translation Entry Overlap Scanner

This block checks a candidate translation entry, before it is installed, against every resident entry of a translation buffer. Software or a fill engine presents the 64-bit candidate and pulses a start request. The scanner then walks the buffer through an index read port, one index per cycle, and decides for each resident entry whether its virtual range collides with the candidate's range.

Each entry describes a page of 4 KB times a power of four. Its start is the page number rounded down to the page's own size. Two valid entries collide when their ranges intersect and they share an address-space tag. A collision also counts when the resident entry is marked global. The candidate's own global marking plays no part in the test.

When the walk finishes, a signed result gives the single colliding index, or -1 when several entries collide, or -2 when none does. A one-cycle done pulse marks the new result. The result then holds until the next scan completes. The buffer storage, and what the caller does with the result, lie outside the block.

Top module: `tlb_overlap_scan`

## Requirements
- R1: After reset `busy` and `done` are 0 and `result` reads -2.
- R2: An entry whose bit 63 (valid) is clear never collides, whether it is the candidate or the resident entry.
- R3: The page number is bits [51:32]. The size code n is the position of the lowest set bit among bits [8:0], or 9 if those bits are all zero. A range covers 4^n pages and starts at the page number with its low 2n bits cleared, so an unaligned page number is rounded down.
- R4: Overlap is detected in both directions: a small candidate inside a large resident page, and a large candidate covering a small resident page.
- R5: Intersecting ranges collide only when the 7-bit tags in bits [58:52] are equal, unless bit 62 (global) of the resident entry is set.
- R6: Bit 62 of the candidate has no effect on the result.
- R7: `result` is a 16-bit signed value. It holds the colliding index when exactly one entry collides, -1 when two or more collide, and -2 when none does.
- R8: Once a start is accepted, `rd_idx` is 0 in the next cycle. It then advances by one per cycle up to N-1 and stays there, so every index is visited. Read data is expected one cycle after its index.
- R9: `done` is a one-cycle pulse that appears N+2 cycles after the edge that accepted the start. `busy` falls in that same cycle. `result` changes only in a cycle where `done` is high.
- R10: A start request while `busy` is high is ignored. The running scan neither restarts nor changes its result, and no extra done pulse follows.
- R11: The candidate is captured when the start is accepted. Later changes on `cand_entry` during the scan do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a scan; accepted only while idle |
| cand_entry | input | 64 | Candidate entry, captured when the start is accepted |
| rd_idx | output | IDX_W | Index presented to the buffer's read port |
| rd_data | input | 64 | Resident entry for the index of the previous cycle |
| busy | output | 1 | A scan is running |
| done | output | 1 | One-cycle pulse: a new result is available |
| result | output | 16 | Signed outcome: index, -1 (several), or -2 (none) |

## Verification
Two events can meet in the same cycle. The first is the done pulse of one scan; the second is a new start request, either one held high during a scan or one raised in the very cycle the previous done appears. The bench raises a start mid-scan with a different candidate. It checks that the index walk keeps going, that the first result arrives on time, and that no second done follows. It also raises a start in the done cycle itself. That start must be accepted on the next edge, while the old result stays readable through the whole new walk until the new done replaces it.

// File: rtl/tlbov_pkg.sv
package tlbov_pkg;

  localparam int ENTRY_W  = 64;
  localparam int VPN_W    = 20;
  localparam int TAG_W    = 7;
  localparam int SZ_MAX   = 9;
  localparam int RES_MULTI = -1;
  localparam int RES_NONE  = -2;

  typedef logic [ENTRY_W-1:0] entry_t;

  function automatic logic ent_valid(input entry_t e);
    return e[63];
  endfunction

  function automatic logic ent_global(input entry_t e);
    return e[62];
  endfunction

  function automatic logic [TAG_W-1:0] ent_tag(input entry_t e);
    return e[58:52];
  endfunction

  function automatic logic [VPN_W-1:0] ent_page(input entry_t e);
    return e[51:32];
  endfunction

  // lowest set bit among [8:0]; 9 when none is set
  function automatic logic [3:0] size_code(input entry_t e);
    logic [3:0] code;
    code = 4'(SZ_MAX);
    for (int i = SZ_MAX - 1; i >= 0; i--) begin
      if (e[i]) code = 4'(i);
    end
    return code;
  endfunction

  function automatic logic [VPN_W:0] span_pages(input entry_t e);
    return (VPN_W+1)'(1) << {size_code(e), 1'b0};
  endfunction

  function automatic logic [VPN_W:0] range_lo(input entry_t e);
    logic [VPN_W:0] span;
    span = span_pages(e);
    return {1'b0, ent_page(e)} & ~(span - (VPN_W+1)'(1));
  endfunction

  function automatic logic ranges_meet(input entry_t a, input entry_t b);
    logic [VPN_W+1:0] a_lo, a_hi, b_lo, b_hi;
    a_lo = {1'b0, range_lo(a)};
    b_lo = {1'b0, range_lo(b)};
    a_hi = a_lo + {1'b0, span_pages(a)};
    b_hi = b_lo + {1'b0, span_pages(b)};
    return ((a_lo <= b_lo) && (b_lo < a_hi)) ||
           ((b_lo <= a_lo) && (a_lo < b_hi));
  endfunction

  // candidate global bit deliberately not consulted
  function automatic logic entries_collide(input entry_t cand, input entry_t res);
    logic same_space;
    same_space = (ent_tag(cand) == ent_tag(res)) || ent_global(res);
    return ent_valid(cand) && ent_valid(res) && ranges_meet(cand, res) && same_space;
  endfunction

endpackage

// File: rtl/tlbov_seq.sv
module tlbov_seq #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             accept,
  output logic             busy,
  output logic [IDX_W-1:0] rd_idx,
  output logic             eval_vld,
  output logic [IDX_W-1:0] eval_idx,
  output logic             finish
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N - 1);

  logic issuing;
  logic last_q;
  logic fin_q;

  assign accept = start && !busy;
  assign finish = fin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      issuing  <= 1'b0;
      rd_idx   <= '0;
      eval_vld <= 1'b0;
      eval_idx <= '0;
      last_q   <= 1'b0;
      fin_q    <= 1'b0;
    end else begin
      eval_vld <= issuing;
      eval_idx <= rd_idx;
      last_q   <= issuing && (rd_idx == LAST_IDX);
      fin_q    <= last_q;
      if (accept) begin
        busy    <= 1'b1;
        issuing <= 1'b1;
        rd_idx  <= '0;
      end else begin
        if (issuing) begin
          if (rd_idx == LAST_IDX) issuing <= 1'b0;
          else                    rd_idx  <= rd_idx + 1'b1;
        end
        if (fin_q) busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tlbov_match.sv
module tlbov_match
  import tlbov_pkg::*;
(
  input  entry_t cand,
  input  entry_t resident,
  input  logic   eval_vld,
  output logic   hit
);

  always_comb begin
    hit = eval_vld && entries_collide(cand, resident);
  end

endmodule

// File: rtl/tlbov_tally.sv
module tlbov_tally #(
  parameter int IDX_W = 4,
  parameter int RES_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    hit,
  input  logic [IDX_W-1:0]        hit_idx,
  input  logic                    finish,
  output logic                    done,
  output logic signed [RES_W-1:0] result
);

  logic [1:0]       n_hits;
  logic [IDX_W-1:0] hit_pos;

  function automatic logic signed [RES_W-1:0] encode(input logic [1:0] cnt,
                                                      input logic [IDX_W-1:0] pos);
    case (cnt)
      2'd0:    return RES_W'(tlbov_pkg::RES_NONE);
      2'd1:    return RES_W'({1'b0, pos});
      default: return RES_W'(tlbov_pkg::RES_MULTI);
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_hits  <= 2'd0;
      hit_pos <= '0;
      done    <= 1'b0;
      result  <= RES_W'(tlbov_pkg::RES_NONE);
    end else begin
      done <= finish;
      if (finish) result <= encode(n_hits, hit_pos);
      if (clear) begin
        n_hits <= 2'd0;
      end else if (hit) begin
        if (n_hits != 2'd2) n_hits <= n_hits + 2'd1;
        hit_pos <= hit_idx;
      end
    end
  end

endmodule

// File: rtl/tlb_overlap_scan.sv
module tlb_overlap_scan
  import tlbov_pkg::*;
#(
  parameter int N     = 16,
  parameter int RES_W = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [63:0]             cand_entry,
  output logic [IDX_W-1:0]        rd_idx,
  input  logic [63:0]             rd_data,
  output logic                    busy,
  output logic                    done,
  output logic signed [RES_W-1:0] result
);

  entry_t           cand_q;
  logic             accept_w;
  logic             eval_vld_w;
  logic [IDX_W-1:0] eval_idx_w;
  logic             finish_w;
  logic             hit_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cand_q <= '0;
    else if (accept_w) cand_q <= cand_entry;
  end

  tlbov_seq #(.N(N), .IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .accept   (accept_w),
    .busy     (busy),
    .rd_idx   (rd_idx),
    .eval_vld (eval_vld_w),
    .eval_idx (eval_idx_w),
    .finish   (finish_w)
  );

  tlbov_match u_match (
    .cand     (cand_q),
    .resident (rd_data),
    .eval_vld (eval_vld_w),
    .hit      (hit_w)
  );

  tlbov_tally #(.IDX_W(IDX_W), .RES_W(RES_W)) u_tally (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept_w),
    .hit     (hit_w),
    .hit_idx (eval_idx_w),
    .finish  (finish_w),
    .done    (done),
    .result  (result)
  );

endmodule

// File: rtl/tlbov_chk.sv
module tlbov_chk #(
  parameter int N     = 16,
  parameter int RES_W = 16,
  parameter int IDX_W = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    busy,
  input logic                    done,
  input logic signed [RES_W-1:0] result,
  input logic [IDX_W-1:0]        rd_idx,
  input logic                    hit,
  input logic                    eval_vld
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N - 1);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_result_only_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);

  p_result_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result == RES_W'(-1) || result == RES_W'(-2) ||
              (result >= 0 && result < RES_W'(N))));

  p_walk_starts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (rd_idx == '0));

  p_walk_steps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(rd_idx) != LAST_IDX) |-> (rd_idx == $past(rd_idx) + 1'b1));

  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && rd_idx != '0) |=> (rd_idx != '0));

  p_hit_in_walk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && eval_vld) |-> busy);

endmodule

bind tlb_overlap_scan tlbov_chk #(.N(N), .RES_W(RES_W), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .result   (result),
  .rd_idx   (rd_idx),
  .hit      (hit_w),
  .eval_vld (eval_vld_w)
);

// File: tb/sim_tlb_overlap_scan.sv
`timescale 1ns/1ps
module sim_tlb_overlap_scan;

  localparam int N = 16;
  localparam int IW = 4;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic [63:0]        cand = '0;
  logic [IW-1:0]      rd_idx;
  logic [63:0]        rd_data = '0;
  logic               busy;
  logic               done;
  logic signed [15:0] res;
  logic [63:0]        mem [N];

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) rd_data <= mem[rd_idx];

  tlb_overlap_scan #(.N(N), .RES_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cand_entry(cand),
    .rd_idx(rd_idx), .rd_data(rd_data), .busy(busy), .done(done), .result(res)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input bit v, input bit g, input int tag,
                                     input int page, input int n);
    logic [63:0] e;
    e = '0;
    e[63] = v;
    e[62] = g;
    e[58:52] = tag[6:0];
    e[51:32] = page[19:0];
    e[n] = 1'b1;
    return e;
  endfunction

  task automatic wipe();
    for (int i = 0; i < N; i++) mem[i] = '0;
  endtask

  // start already driven before the accepting edge
  task automatic finish_scan(input int exp, input string req,
                             input int poke_at, input bit poke_start,
                             input logic [63:0] poke_cand,
                             input bit hold_chk, input int hold_exp);
    bit walk_ok = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (rd_idx !== IW'(k)) walk_ok = 1'b0;
      if (k == poke_at) begin start = poke_start; cand = poke_cand; end
      if (k == poke_at + 1) start = 1'b0;
      if (hold_chk && k == N/2)
        check(res === 16'(hold_exp), "R9", "result held during next walk", res, hold_exp);
      if (k < N - 1) begin @(posedge clk); @(negedge clk); end
    end
    start = 1'b0;
    check(walk_ok, "R8", "index walk 0..N-1", walk_ok, 1);
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    check(done === 1'b0, "R9", "done early", done, 0);
    @(posedge clk); @(negedge clk);
    check(done === 1'b1 && busy === 1'b0, "R9", "done at N+2", done, 1);
    check(res === 16'(exp), req, "result", res, exp);
  endtask

  task automatic scan(input logic [63:0] c, input int exp, input string req);
    @(negedge clk);
    start = 1'b1;
    cand = c;
    finish_scan(exp, req, -5, 1'b0, c, 1'b0, 0);
  endtask

  task automatic t_reset();
    check(busy === 1'b0, "R1", "busy after reset", busy, 0);
    check(done === 1'b0, "R1", "done after reset", done, 0);
    check(res === -16'sd2, "R1", "result after reset", res, -2);
  endtask

  task automatic t_valid();
    wipe();
    scan(mk(1, 0, 3, 'h40, 0), -2, "R2");
    mem[8] = mk(0, 0, 3, 'h40, 0);
    scan(mk(1, 0, 3, 'h40, 0), -2, "R2");
    mem[8] = mk(1, 0, 3, 'h40, 0);
    scan(mk(0, 0, 3, 'h40, 0), -2, "R2");
  endtask

  task automatic t_encode();
    wipe();
    mem[5] = mk(1, 0, 3, 'h50, 0);
    scan(mk(1, 0, 3, 'h50, 0), 5, "R7");
    wipe();
    mem[15] = mk(1, 0, 3, 'h51, 0);
    scan(mk(1, 0, 3, 'h51, 0), 15, "R8");
    wipe();
    mem[4] = mk(1, 0, 3, 'h52, 0);
    mem[11] = mk(1, 0, 3, 'h52, 0);
    scan(mk(1, 0, 3, 'h52, 0), -1, "R7");
  endtask

  task automatic t_sizes();
    wipe();
    mem[3] = mk(1, 0, 2, 'h100, 4);
    scan(mk(1, 0, 2, 'h1A5, 0), 3, "R4");
    wipe();
    mem[7] = mk(1, 0, 2, 'h2A5, 0);
    scan(mk(1, 0, 2, 'h280, 3), 7, "R4");
    wipe();
    mem[9] = mk(1, 0, 2, 'h10F, 2);
    scan(mk(1, 0, 2, 'h100, 0), 9, "R3");
    scan(mk(1, 0, 2, 'h110, 0), -2, "R3");
  endtask

  task automatic t_tags();
    wipe();
    mem[6] = mk(1, 0, 1, 'h77, 0);
    scan(mk(1, 0, 2, 'h77, 0), -2, "R5");
    scan(mk(1, 1, 2, 'h77, 0), -2, "R6");
    mem[6] = mk(1, 1, 1, 'h77, 0);
    scan(mk(1, 0, 2, 'h77, 0), 6, "R5");
  endtask

  task automatic t_busy_start();
    bit quiet = 1'b1;
    wipe();
    mem[2] = mk(1, 0, 4, 'h90, 0);
    mem[9] = mk(1, 0, 4, 'hA0, 0);
    @(negedge clk);
    start = 1'b1;
    cand = mk(1, 0, 4, 'h90, 0);
    finish_scan(2, "R10", 5, 1'b1, mk(1, 0, 4, 'hA0, 0), 1'b0, 0);
    for (int k = 0; k < N + 4; k++) begin
      @(posedge clk); @(negedge clk);
      if (done !== 1'b0 || busy !== 1'b0) quiet = 1'b0;
    end
    check(quiet, "R10", "no second scan", quiet, 1);
    @(negedge clk);
    start = 1'b1;
    cand = mk(1, 0, 4, 'h90, 0);
    finish_scan(2, "R11", 0, 1'b0, mk(1, 0, 4, 'hA0, 0), 1'b0, 0);
  endtask

  task automatic t_back_to_back();
    wipe();
    mem[5] = mk(1, 0, 6, 'h300, 0);
    mem[12] = mk(1, 0, 6, 'h400, 0);
    scan(mk(1, 0, 6, 'h300, 0), 5, "R9");
    start = 1'b1;
    cand = mk(1, 0, 6, 'h400, 0);
    finish_scan(12, "R9", -5, 1'b0, cand, 1'b1, 5);
  endtask

  initial begin
    #(5.0 * 200000);
    check(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wipe();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_valid();
    t_encode();
    t_sizes();
    t_tags();
    t_busy_start();
    t_back_to_back();
    repeat (4) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule